// File: doc/BRIEF.md
# Bit-Slip Word Aligner

This block sits behind a deserializer whose parallel words may start at the wrong bit of the serial stream. An external controller moves the word boundary one bit at a time. Each rising edge on the slip request advances a slip offset by one, and the aligned word is cut from a window made of the current input word and the word before it. The current offset is reported as a 5-bit status value, so the controller can tell how far the boundary has moved.

The word width is 8 or 10 bits. A static configuration input selects it, and that input is only changed while the block is held in reset. With slipping disabled, input words pass straight through and slip requests are ignored. The edge detector keeps tracking the request line in that state, so a request that is already high when slipping is re-enabled does not cause a slip.

Bit 0 of an input word is the earliest bit received. The window is {current word, previous word} with the current word in the upper half. The output word is that window shifted right by the offset, keeping the lowest word-width bits. When the same word repeats, each slip rotates the output right by one bit.

Top module: `bitslip_aligner`

## Requirements
- R1: While reset is asserted, `aligned_word` reads 0 and `slip_offset` reads 0.
- R2: With `slip_en` high, a clock edge that samples `slip_req` high after it was sampled low on the previous edge raises `slip_offset` by one at that edge.
- R3: Holding `slip_req` high for more than one cycle produces exactly one slip.
- R4: The offset wraps from 7 to 0 when `cfg_wide` is 0 (8-bit mode) and from 9 to 0 when `cfg_wide` is 1 (10-bit mode).
- R5: With slipping enabled, after each clock edge `aligned_word` equals the word-width bits starting at bit `slip_offset` (the value held before that edge) of {`rx_word`, previous `rx_word`}. For a repeating 0xBC in 8-bit mode, offsets 3, 4 and 7 give 0x97, 0xCB and 0x79. For a repeating 0x3BC in 10-bit mode, offsets 6 to 9 give 0x3CE, 0x1E7, 0x2F3 and 0x379.
- R6: In 8-bit mode, `rx_word[9:8]` is ignored and `aligned_word[9:8]` is 0.
- R7: With `slip_en` low, `aligned_word` equals the `rx_word` sampled at the previous edge (only bits 7:0 in 8-bit mode), and slip requests leave `slip_offset` unchanged.
- R8: A new offset first affects `aligned_word` at the clock edge after the edge where the offset changed.
- R9: Toggling `slip_req` gives one slip for each rising edge, including on consecutive pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Parallel word clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously, released in step with clk |
| cfg_wide | input | 1 | Word width select: 1 = 10-bit, 0 = 8-bit; static outside reset |
| slip_en | input | 1 | 1 enables slipping, 0 passes input words through |
| slip_req | input | 1 | Slip request, synchronous to clk; one slip for each rising edge |
| rx_word | input | 10 | Parallel word from the deserializer |
| aligned_word | output | 10 | Realigned word, registered |
| slip_offset | output | 5 | Current slip offset |

## Verification
The assertions assume that `slip_req` is already synchronous to `clk` and that `cfg_wide` changes only while reset is asserted. The offset-range and upper-bit checks rely on the width staying fixed. The stimulus drives every input on the falling edge, changes the width only inside a reset, and produces requests as single-cycle pulses, held-high stretches and requests made while slipping is disabled. Repeating and pseudo-random data are both used, so the window is tested across word boundaries and not only with rotations.

// File: rtl/bsa_pkg.sv
package bsa_pkg;
  localparam int WIDE_W   = 10;
  localparam int NARROW_W = 8;
  localparam int OFF_W    = 5;

  typedef logic [OFF_W-1:0] off_t;

  // Highest legal offset for the configured word width.
  function automatic off_t last_off(input logic wide);
    return wide ? off_t'(WIDE_W - 1) : off_t'(NARROW_W - 1);
  endfunction
endpackage

// File: rtl/bsa_edge_det.sv
module bsa_edge_det (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  output logic rise
);
  logic req_q;
  logic req_nxt;

  always_comb req_nxt = req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_q <= 1'b0;
    else        req_q <= req_nxt;
  end

  assign rise = req & ~req_q;

  // A held request can never yield two edges in a row.
  assert_single_edge_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);
endmodule

// File: rtl/bsa_offset_ctr.sv
module bsa_offset_ctr
  import bsa_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic step,
  input  logic wide,
  output off_t off
);
  off_t off_q;
  off_t off_nxt;
  off_t off_last;
  logic off_en;

  always_comb begin
    off_last = last_off(wide);
    off_en   = step;
    off_nxt  = (off_q >= off_last) ? '0 : off_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      off_q <= '0;
    else if (off_en) off_q <= off_nxt;
  end

  assign off = off_q;

  assert_in_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    off_q <= last_off(wide));

  assert_step_one_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (step && off_q < last_off(wide)) |=> off_q == off_t'($past(off_q) + 1'b1));

  assert_wrap_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (step && off_q == last_off(wide)) |=> off_q == '0);

  assert_no_step_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(off_q));
endmodule

// File: rtl/bsa_window.sv
module bsa_window #(
  parameter int W     = 8,
  parameter int OFF_W = 5
) (
  input  logic [W-1:0]     cur,
  input  logic [W-1:0]     prev,
  input  logic [OFF_W-1:0] off,
  output logic [W-1:0]     word
);
  localparam int PAIR_W = 2 * W;

  logic [PAIR_W-1:0] pair;
  logic [PAIR_W-1:0] shifted;

  always_comb begin
    pair    = {cur, prev};
    shifted = pair >> off;
    word    = shifted[W-1:0];
  end
endmodule

// File: rtl/bsa_shifter.sv
module bsa_shifter
  import bsa_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wide,
  input  logic              bypass,
  input  logic [WIDE_W-1:0] in_word,
  input  off_t              off,
  output logic [WIDE_W-1:0] out_word
);
  localparam int LANES = 2;

  logic [WIDE_W-1:0] prev_q;
  logic [WIDE_W-1:0] prev_nxt;
  logic [WIDE_W-1:0] out_q;
  logic [WIDE_W-1:0] out_nxt;
  logic [WIDE_W-1:0] pass_word;
  logic [WIDE_W-1:0] lane_word [LANES];

  // Lane 0 serves 8-bit mode and lane 1 serves 10-bit mode.
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    localparam int LW = (g == 0) ? NARROW_W : WIDE_W;
    logic [LW-1:0] sel;
    bsa_window #(.W(LW), .OFF_W(OFF_W)) u_win (
      .cur  (in_word[LW-1:0]),
      .prev (prev_q[LW-1:0]),
      .off  (off),
      .word (sel)
    );
    assign lane_word[g] = WIDE_W'(sel);
  end

  always_comb begin
    prev_nxt  = in_word;
    pass_word = wide ? in_word : WIDE_W'(in_word[NARROW_W-1:0]);
    out_nxt   = bypass ? pass_word : lane_word[wide];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      out_q  <= '0;
    end else begin
      prev_q <= prev_nxt;
      out_q  <= out_nxt;
    end
  end

  assign out_word = out_q;

  assert_narrow_upper_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !wide |=> out_q[WIDE_W-1:NARROW_W] == '0);

  assert_bypass_pass_R7: assert property (@(posedge clk) disable iff (!rst_n)
    bypass |=> out_q == $past(wide ? in_word : WIDE_W'(in_word[NARROW_W-1:0])));
endmodule

// File: rtl/bitslip_aligner.sv
module bitslip_aligner
  import bsa_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wide,
  input  logic              slip_en,
  input  logic              slip_req,
  input  logic [WIDE_W-1:0] rx_word,
  output logic [WIDE_W-1:0] aligned_word,
  output logic [OFF_W-1:0]  slip_offset
);
  logic req_rise;
  logic slip_step;
  off_t cur_off;

  bsa_edge_det u_edge (
    .clk  (clk),
    .rst_n(rst_n),
    .req  (slip_req),
    .rise (req_rise)
  );

  assign slip_step = req_rise & slip_en;

  bsa_offset_ctr u_ctr (
    .clk  (clk),
    .rst_n(rst_n),
    .step (slip_step),
    .wide (cfg_wide),
    .off  (cur_off)
  );

  bsa_shifter u_shift (
    .clk     (clk),
    .rst_n   (rst_n),
    .wide    (cfg_wide),
    .bypass  (!slip_en),
    .in_word (rx_word),
    .off     (cur_off),
    .out_word(aligned_word)
  );

  assign slip_offset = cur_off;

  assert_disabled_offset_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !slip_en |=> $stable(slip_offset));
endmodule

// File: tb/test_bitslip_aligner.sv
module test_bitslip_aligner;
  localparam int CLK_PERIOD = 10;

  logic       clk;
  logic       rst_n;
  logic       cfg_wide;
  logic       slip_en;
  logic       slip_req;
  logic [9:0] rx_word;
  logic [9:0] aligned_word;
  logic [4:0] slip_offset;

  bitslip_aligner i_bitslip_aligner (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_wide    (cfg_wide),
    .slip_en     (slip_en),
    .slip_req    (slip_req),
    .rx_word     (rx_word),
    .aligned_word(aligned_word),
    .slip_offset (slip_offset)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int errs = 0;
  int checks = 0;
  bit done = 0;

  // Reference model state, built from the requirements.
  logic [9:0] m_prev;
  int         m_off;
  logic       m_reqd;
  logic       m_wide;
  logic [15:0] lfsr = 16'hACE1;

  logic [9:0] q_out [$];
  int         q_off [$];
  string      q_tag [$];

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [9:0] sel_model(input logic [9:0] w, input logic [9:0] p,
                                           input int off, input logic wide);
    logic [19:0] win;
    logic [19:0] sh;
    win = wide ? {w, p} : {4'b0000, w[7:0], p[7:0]};
    sh  = win >> off;
    return wide ? sh[9:0] : {2'b00, sh[7:0]};
  endfunction

  // Driver: set inputs on the falling edge and queue what the next rising edge must produce.
  task automatic drive(input logic [9:0] w, input logic r, input logic en, input string tag);
    logic [9:0] e;
    int last;
    @(negedge clk);
    rx_word  = w;
    slip_req = r;
    slip_en  = en;
    last = m_wide ? 9 : 7;
    e = en ? sel_model(w, m_prev, m_off, m_wide) : (m_wide ? w : {2'b00, w[7:0]});
    if (en && r && !m_reqd) m_off = (m_off >= last) ? 0 : m_off + 1;
    m_reqd = r;
    m_prev = w;
    q_out.push_back(e);
    q_off.push_back(m_off);
    q_tag.push_back(tag);
  endtask

  // Monitor: compare each queued item a quarter period after the rising edge.
  initial begin
    forever begin
      @(posedge clk);
      #(CLK_PERIOD/4);
      if (q_out.size() > 0) begin
        logic [9:0] e;
        int o;
        string t;
        e = q_out.pop_front();
        o = q_off.pop_front();
        t = q_tag.pop_front();
        chk({t, " word"}, 16'(aligned_word), 16'(e));
        chk({t, " offset"}, 16'(slip_offset), 16'(o));
      end
    end
  end

  task automatic do_reset(input logic wide);
    @(negedge clk);
    rst_n = 1'b0;
    slip_req = 1'b0;
    slip_en = 1'b1;
    rx_word = '0;
    cfg_wide = wide;
    m_prev = '0; m_off = 0; m_reqd = 1'b0; m_wide = wide;
    repeat (2) @(posedge clk);
    #(CLK_PERIOD/4);
    chk("R1 reset word", 16'(aligned_word), 16'h0);
    chk("R1 reset offset", 16'(slip_offset), 16'h0);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic expect_now(input logic [9:0] val, input int off, input string tag);
    @(posedge clk);
    #(CLK_PERIOD/4);
    chk({tag, " direct word"}, 16'(aligned_word), 16'(val));
    chk({tag, " direct offset"}, 16'(slip_offset), 16'(off));
  endtask

  task automatic pulse(input logic [9:0] w, input logic en, input string tag);
    drive(w, 1'b1, en, tag);
    drive(w, 1'b0, en, tag);
  endtask

  task automatic settle(input logic [9:0] w, input int n);
    for (int i = 0; i < n; i++) drive(w, 1'b0, 1'b1, "R5 settle");
  endtask

  task automatic step_lfsr();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
  endtask

  initial begin
    #(CLK_PERIOD*200000);
    if (!done) begin
      errs++;
      checks++;
      $display("FAIL watchdog (R1..R9 run): actual timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cfg_wide = 1'b0; slip_en = 1'b1; slip_req = 1'b0; rx_word = '0;
    m_prev = '0; m_off = 0; m_reqd = 1'b0; m_wide = 1'b0;

    // 8-bit mode, repeating 0xBC with the upper input bits set (R6).
    do_reset(1'b0);
    settle(10'h3BC, 3);
    expect_now(10'h0BC, 0, "R6 upper bits ignored");
    for (int i = 0; i < 3; i++) pulse(10'h3BC, 1'b1, "R9 toggle");
    settle(10'h3BC, 2);
    expect_now(10'h097, 3, "R5 8-bit offset 3");
    for (int i = 0; i < 4; i++) drive(10'h3BC, 1'b1, 1'b1, "R3 held request");
    drive(10'h3BC, 1'b0, 1'b1, "R3 release");
    settle(10'h3BC, 2);
    expect_now(10'h0CB, 4, "R3 one slip only");
    for (int i = 0; i < 3; i++) pulse(10'h3BC, 1'b1, "R2 increment");
    settle(10'h3BC, 2);
    expect_now(10'h079, 7, "R5 8-bit offset 7");
    pulse(10'h3BC, 1'b1, "R4 wrap narrow");
    settle(10'h3BC, 2);
    expect_now(10'h0BC, 0, "R4 wrap narrow");

    // Changing data across offset changes (R5, R8).
    for (int i = 0; i < 40; i++) begin
      step_lfsr();
      drive(lfsr[9:0], (i % 5 == 1), 1'b1, "R8 varying data");
    end

    // Bypass: requests ignored, words pass through (R7).
    for (int i = 0; i < 12; i++) begin
      step_lfsr();
      drive(lfsr[9:0], (i % 3 == 0), 1'b0, "R7 bypass");
    end
    drive(10'h155, 1'b1, 1'b0, "R7 request while disabled");
    drive(10'h155, 1'b1, 1'b1, "R7 enable while high");
    drive(10'h155, 1'b0, 1'b1, "R7 offset kept");

    // 10-bit mode, repeating 0x3BC.
    do_reset(1'b1);
    settle(10'h3BC, 3);
    expect_now(10'h3BC, 0, "R5 10-bit offset 0");
    for (int i = 0; i < 6; i++) pulse(10'h3BC, 1'b1, "R9 toggle wide");
    settle(10'h3BC, 2);
    expect_now(10'h3CE, 6, "R5 10-bit offset 6");
    pulse(10'h3BC, 1'b1, "R2 wide");
    settle(10'h3BC, 2);
    expect_now(10'h1E7, 7, "R5 10-bit offset 7");
    pulse(10'h3BC, 1'b1, "R2 wide");
    settle(10'h3BC, 2);
    expect_now(10'h2F3, 8, "R5 10-bit offset 8");
    pulse(10'h3BC, 1'b1, "R2 wide");
    settle(10'h3BC, 2);
    expect_now(10'h379, 9, "R5 10-bit offset 9");
    pulse(10'h3BC, 1'b1, "R4 wrap wide");
    settle(10'h3BC, 2);
    expect_now(10'h3BC, 0, "R4 wrap wide");

    for (int i = 0; i < 60; i++) begin
      step_lfsr();
      drive(lfsr[9:0], lfsr[11], 1'b1, "R8 varying wide");
    end
    for (int i = 0; i < 8; i++) begin
      step_lfsr();
      drive(lfsr[9:0], lfsr[12], 1'b0, "R7 bypass wide");
    end
    settle(10'h000, 3);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule